// File: doc/BRIEF.md
# Two-Channel Weighted DMA Arbiter

This block decides which of two DMA engines, one moving received data and one moving data for transmission, may use the shared host bus next. Each engine raises a request line and keeps it high until it is granted. The arbiter gives out one grant per bus transaction. It keeps that grant until the owning engine pulses its done line.

Two static configuration inputs select the policy. With the strict-priority bit set, a waiting receive engine always wins over a waiting transmit engine. With the bit clear, a 2-bit weight sets how many contested grants the receive side wins in a row before the transmit side gets one. The weight runs from 1:1 up to 4:1. A small counter tracks the receive wins. Only contested decisions move this counter, and it is held at zero while strict priority is selected. Grants are registered outputs.

Top module: `dma_wrr_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both grant outputs are low.
- R2: At most one grant output is high at any time. A grant only rises for a channel whose request was high on the cycle before.
- R3: A grant stays high until the granted channel pulses its own done input. A done pulse from the channel that is not granted has no effect on either grant.
- R4: On the edge that samples the granted channel's done, the grant drops. Both grants are then low for one cycle, and the next arbitration takes place on the following edge.
- R5: When no grant is held and at least one request is high, a grant is issued on the next clock edge.
- R6: With `rx_first_i` = 1, a contested decision (both requests high) always grants the receive channel.
- R7: With `rx_first_i` = 0 and `weight_i` = w (00, 01, 10, 11 giving 1:1, 2:1, 3:1, 4:1), continuous contention produces w+1 receive grants followed by one transmit grant, and the pattern repeats.
- R8: A lone requester is granted at once, whatever the win counter holds. Uncontested grants leave the counter unchanged. Example: with w=00, one contested receive win, then a lone receive grant, then contention gives transmit.
- R9: The win counter is cleared by reset and held at zero while `rx_first_i` = 1. After a return to weighted mode, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_first_i | input | 1 | 1 = strict receive priority, 0 = weighted round robin |
| weight_i | input | 2 | Receive:transmit ratio code, value w gives (w+1):1 |
| rx_req_i | input | 1 | Receive engine request, held until granted |
| tx_req_i | input | 1 | Transmit engine request, held until granted |
| rx_done_i | input | 1 | One-cycle pulse ending a receive transaction |
| tx_done_i | input | 1 | One-cycle pulse ending a transmit transaction |
| rx_gnt_o | output | 1 | Receive channel owns the bus |
| tx_gnt_o | output | 1 | Transmit channel owns the bus |

## Verification
A grant appears one edge after a request meets an idle arbiter. It clears one edge after the owner's done pulse. The earliest the next grant can appear is one edge later again, so a fully loaded handshake repeats every two cycles. The bench drives every input on a falling edge. It reads the grants on the next falling edge to see the result of an issue, and on the falling edge after the done pulse to see the idle gap. Each sweep over mode and weight code compares the granted channel against an index computed modulo w+2.

// File: rtl/dma_wrr_arbiter.sv
module dma_wrr_arbiter #(
  parameter int WEIGHT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_first_i,
  input  logic [WEIGHT_W-1:0] weight_i,
  input  logic                rx_req_i,
  input  logic                tx_req_i,
  input  logic                rx_done_i,
  input  logic                tx_done_i,
  output logic                rx_gnt_o,
  output logic                tx_gnt_o
);
  localparam int CNT_W = WEIGHT_W + 1;

  logic [CNT_W-1:0] wins_q;
  logic [CNT_W-1:0] limit;
  logic             busy, contested, tx_turn, pick_rx, pick_tx, release_now;

  assign limit       = CNT_W'(weight_i) + CNT_W'(1);
  assign busy        = rx_gnt_o | tx_gnt_o;
  assign contested   = rx_req_i & tx_req_i;
  assign tx_turn     = !rx_first_i && (wins_q >= limit);
  assign pick_rx     = rx_req_i & (!tx_req_i | !tx_turn);
  assign pick_tx     = tx_req_i & !pick_rx;
  assign release_now = (rx_gnt_o & rx_done_i) | (tx_gnt_o & tx_done_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_gnt_o <= 1'b0;
      tx_gnt_o <= 1'b0;
    end else if (busy) begin
      if (release_now) begin
        rx_gnt_o <= 1'b0;
        tx_gnt_o <= 1'b0;
      end
    end else begin
      rx_gnt_o <= pick_rx;
      tx_gnt_o <= pick_tx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wins_q <= '0;
    else if (rx_first_i)
      wins_q <= '0;
    else if (!busy && contested)
      wins_q <= pick_rx ? wins_q + CNT_W'(1) : '0;
  end
endmodule

module dma_wrr_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_first_i,
  input logic rx_req_i,
  input logic tx_req_i,
  input logic rx_done_i,
  input logic tx_done_i,
  input logic rx_gnt_o,
  input logic tx_gnt_o
);
  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_gnt_o, tx_gnt_o}) <= 1);

  assert_rx_rise_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_gnt_o) |-> $past(rx_req_i));

  assert_tx_rise_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_gnt_o) |-> $past(tx_req_i));

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_gnt_o && !rx_done_i) |=> rx_gnt_o);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt_o && !tx_done_i) |=> tx_gnt_o);

  assert_idle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_gnt_o && rx_done_i) || (tx_gnt_o && tx_done_i)) |=> !(rx_gnt_o || tx_gnt_o));

  assert_prompt_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_gnt_o && !tx_gnt_o && (rx_req_i || tx_req_i)) |=> (rx_gnt_o || tx_gnt_o));

  assert_strict_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_first_i && !rx_gnt_o && !tx_gnt_o && rx_req_i && tx_req_i) |=> rx_gnt_o);
endmodule

bind dma_wrr_arbiter dma_wrr_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_first_i(rx_first_i),
  .rx_req_i(rx_req_i), .tx_req_i(tx_req_i),
  .rx_done_i(rx_done_i), .tx_done_i(tx_done_i),
  .rx_gnt_o(rx_gnt_o), .tx_gnt_o(tx_gnt_o)
);

// File: tb/dma_wrr_arbiter_test.sv
module dma_wrr_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_first_i = 1'b0;
  logic [1:0] weight_i = 2'd0;
  logic       rx_req_i = 1'b0, tx_req_i = 1'b0;
  logic       rx_done_i = 1'b0, tx_done_i = 1'b0;
  logic       rx_gnt_o, tx_gnt_o;
  int         n_run = 0, n_fail = 0, cycles = 0;

  always #10 clk = ~clk;

  dma_wrr_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rx_first_i(rx_first_i), .weight_i(weight_i),
    .rx_req_i(rx_req_i), .tx_req_i(tx_req_i),
    .rx_done_i(rx_done_i), .tx_done_i(tx_done_i),
    .rx_gnt_o(rx_gnt_o), .tx_gnt_o(tx_gnt_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // grant code: 2'b01 = receive, 2'b10 = transmit, 2'b00 = none
  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_req_i = 0; tx_req_i = 0; rx_done_i = 0; tx_done_i = 0;
    @(negedge clk);
    check({tx_gnt_o, rx_gnt_o}, 2'b00, "R1 in reset");
    rst_n = 1'b1;
  endtask

  // requests already set; grant must appear after one edge, clear after done
  task automatic serve(input logic [1:0] exp, input string req);
    @(negedge clk);
    check({tx_gnt_o, rx_gnt_o}, exp, req);
    rx_done_i = rx_gnt_o; tx_done_i = tx_gnt_o;
    @(negedge clk);
    rx_done_i = 0; tx_done_i = 0;
    check({tx_gnt_o, rx_gnt_o}, 2'b00, "R4 idle gap after done");
  endtask

  initial begin
    do_reset();
    check({tx_gnt_o, rx_gnt_o}, 2'b00, "R1 first cycle after reset");

    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < 4; w++) begin
        rx_first_i = m[0]; weight_i = w[1:0];
        do_reset();
        rx_req_i = 1; tx_req_i = 1;
        for (int i = 0; i < 3 * (w + 2); i++) begin
          if (m == 1) serve(2'b01, "R6 strict contested");
          else serve((i % (w + 2)) == w + 1 ? 2'b10 : 2'b01, "R7 weighted pattern");
        end
      end
    end

    // R8 lone requester ignores counter and does not advance it
    rx_first_i = 0; weight_i = 2'd0;
    do_reset();
    tx_req_i = 1; rx_req_i = 1;
    serve(2'b01, "R8 contested rx win");
    tx_req_i = 0;
    serve(2'b01, "R8 lone rx while tx due");
    tx_req_i = 1;
    serve(2'b10, "R8 counter unchanged by lone grant");
    rx_req_i = 0;
    serve(2'b10, "R8 lone tx");
    rx_req_i = 1;
    serve(2'b01, "R8 rx after tx turn");

    // R3 wrong-channel done ignored
    do_reset();
    rx_req_i = 1; tx_req_i = 0;
    @(negedge clk);
    check({tx_gnt_o, rx_gnt_o}, 2'b01, "R5 grant one edge after request");
    tx_done_i = 1;
    @(negedge clk);
    tx_done_i = 0;
    check({tx_gnt_o, rx_gnt_o}, 2'b01, "R3 foreign done ignored");
    @(negedge clk);
    check({tx_gnt_o, rx_gnt_o}, 2'b01, "R3 grant held without done");
    rx_done_i = 1;
    @(negedge clk);
    rx_done_i = 0;
    check({tx_gnt_o, rx_gnt_o}, 2'b00, "R4 released on own done");
    rx_req_i = 0;
    @(negedge clk);
    check({tx_gnt_o, rx_gnt_o}, 2'b00, "R2 no grant without request");

    // R9 strict interlude clears counter
    rx_first_i = 0; weight_i = 2'd3;
    do_reset();
    rx_req_i = 1; tx_req_i = 1;
    serve(2'b01, "R9 weighted win 1");
    serve(2'b01, "R9 weighted win 2");
    rx_first_i = 1;
    serve(2'b01, "R9 strict interlude");
    rx_first_i = 0;
    for (int i = 0; i < 4; i++) serve(2'b01, "R9 fresh count rx");
    serve(2'b10, "R9 tx after four fresh wins");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule